// File: doc/BRIEF.md
# Clock Domain Retune Sequencer

This block moves a whole clock domain from one operating point to another. The domain has one PLL and a short list of child dividers. A request names a target domain rate. The block looks that rate up in a table of up to six operating points, which is fixed by parameters. Each operating point gives a PLL rate and one divide value for every child divider. The block then programs the PLL and the dividers through a single write port. The PLL controller and the divider registers both sit behind that port.

The order of the writes depends on the direction of the change. The new PLL rate is compared with the PLL rate the block last set successfully. When the PLL goes down, the PLL is written first. When it goes up or stays the same, every divider is written first and the PLL last. Either way, no child clock runs above either of its two settings while the change is in progress. Every write waits for an acknowledge before the next one goes out. The acknowledge of a PLL write carries a response code. Each accepted request ends with a one-cycle done pulse and a status code.

Top module: `domain_retune_seq`

## Requirements
- R1: The request rate is compared with the table slots starting at slot 0. A slot whose target rate is zero ends the search, so that slot and every slot after it can never match. If several slots carry the same rate, the lowest slot is used.
- R2: A request that matches no live slot, including a request for rate 0, gives `done` with `done_status` = 1 (invalid) on the cycle after it is accepted, and no write is issued.
- R3: If the selected PLL rate is strictly below the current PLL rate, the PLL write goes out first and the divider writes follow.
- R4: If the selected PLL rate is greater than or equal to the current PLL rate, all divider writes go out first and the PLL write goes out last.
- R5: Divider writes follow list order. Each one has `wr_to_pll` = 0, `wr_addr` equal to that divider's offset, and `wr_data` equal to the selected slot's divide value, zero-extended. The list ends at the first divider whose offset is zero, and no divider from that point on is ever written.
- R6: A write holds `wr_valid`, `wr_to_pll`, `wr_addr` and `wr_data` steady until `wr_ack` is sampled high. The next write, or `done`, appears on the following cycle.
- R7: A PLL write has `wr_to_pll` = 1, `wr_addr` = `PLL_ADDR`, and `wr_data` equal to the new PLL rate. Its `wr_resp` is read together with `wr_ack`: 0 means ok, 1 means timeout, and 2 or 3 mean error.
- R8: A PLL response other than ok ends the request on the next cycle with `done_status` = 2 (timeout) or 3 (error), and no further writes are issued.
- R9: The current PLL rate starts at `INIT_PLL_RATE`. It changes only when a PLL write is acknowledged as ok, and then takes the value written.
- R10: Every accepted request ends with exactly one single-cycle `done` pulse. When all writes are acknowledged ok, `done_status` = 0 and `done` follows the last acknowledge by one cycle.
- R11: `busy` is high from the cycle after a matching request is accepted until `done`. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Retune request strobe, taken when not busy |
| req_rate | input | RATE_W | Requested domain rate |
| busy | output | 1 | Sequence in progress |
| wr_valid | output | 1 | Write request to the PLL controller or a divider |
| wr_to_pll | output | 1 | Current write targets the PLL |
| wr_addr | output | ADDR_W | Register offset of the current write |
| wr_data | output | RATE_W | PLL rate or zero-extended divide value |
| wr_ack | input | 1 | Write accepted |
| wr_resp | input | 2 | PLL response, read with the acknowledge |
| done | output | 1 | One-cycle end-of-request pulse |
| done_status | output | 2 | 0 ok, 1 invalid, 2 PLL timeout, 3 PLL error |

## Verification
A wrong current-rate register would not be visible at once. It would show up on the next request that crosses the old rate, as a PLL write on the wrong side of the divider writes. Every pair of live operating points is therefore run back to back, so that each stored rate is tested by the next request. A wrong slot or divider index shows up immediately as a wrong `wr_addr` or `wr_data` on the first affected write. A sequencing fault shows up as a wrong number of writes, a write issued after a failed PLL response, or a missing or repeated `done` within a few cycles of the final acknowledge.

// File: rtl/retune_pkg.sv
`timescale 1ns/1ps
// Shared types and codes for the clock domain retune sequencer.
package retune_pkg;

    // Final status reported with the done pulse
    localparam logic [1:0] ST_OK          = 2'd0;
    localparam logic [1:0] ST_INVALID     = 2'd1;
    localparam logic [1:0] ST_PLL_TIMEOUT = 2'd2;
    localparam logic [1:0] ST_PLL_ERROR   = 2'd3;

    // PLL controller response codes, read together with the acknowledge
    localparam logic [1:0] RESP_OK      = 2'd0;
    localparam logic [1:0] RESP_TIMEOUT = 2'd1;

    // Sequencer phase: which kind of write is currently outstanding
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PLL  = 2'd1,
        PH_DIV  = 2'd2
    } phase_e;

endpackage

// File: rtl/retune_rate_match.sv
`timescale 1ns/1ps
// Looks up a requested rate in the operating-point table.
// Assumes: slot i sits at bits [i*RATE_W +: RATE_W] of both tables; a zero
// target rate ends the live part of the table; the lowest matching slot wins.
module retune_rate_match #(
    parameter int                        NUM_VAR   = 6,
    parameter int                        RATE_W    = 16,
    parameter int                        IDX_W     = 3,
    parameter logic [NUM_VAR*RATE_W-1:0] TGT_RATES = '0,
    parameter logic [NUM_VAR*RATE_W-1:0] PLL_RATES = '0
) (
    input  logic [RATE_W-1:0] req_rate,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [RATE_W-1:0] hit_pll_rate
);

    logic [NUM_VAR-1:0] slot_live;
    logic [NUM_VAR-1:0] slot_hit;

    // Live chain: a slot is live only if it and every earlier slot are nonzero
    for (genvar i = 0; i < NUM_VAR; i++) begin : g_slot
        if (i == 0) begin : g_first
            assign slot_live[i] = (TGT_RATES[i*RATE_W +: RATE_W] != '0);
        end else begin : g_rest
            assign slot_live[i] = slot_live[i-1] &&
                                  (TGT_RATES[i*RATE_W +: RATE_W] != '0);
        end
        assign slot_hit[i] = slot_live[i] &&
                             (req_rate == TGT_RATES[i*RATE_W +: RATE_W]);
    end

    // Priority pick: scan downward so the lowest matching slot is kept
    always_comb begin
        hit          = 1'b0;
        hit_idx      = '0;
        hit_pll_rate = '0;
        for (int i = NUM_VAR - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                hit          = 1'b1;
                hit_idx      = IDX_W'(i);
                hit_pll_rate = PLL_RATES[i*RATE_W +: RATE_W];
            end
        end
    end

endmodule

// File: rtl/retune_div_table.sv
`timescale 1ns/1ps
// Selects the offset and divide value of one divider for one operating point.
// Assumes: offset d sits at [d*ADDR_W +: ADDR_W]; the value of slot v and
// divider d sits at [(v*NUM_DIV+d)*DIV_W +: DIV_W]; indices are in range.
module retune_div_table #(
    parameter int                                NUM_VAR  = 6,
    parameter int                                NUM_DIV  = 4,
    parameter int                                IDX_W    = 3,
    parameter int                                DIDX_W   = 2,
    parameter int                                ADDR_W   = 12,
    parameter int                                DIV_W    = 8,
    parameter logic [NUM_DIV*ADDR_W-1:0]         DIV_OFS  = '0,
    parameter logic [NUM_VAR*NUM_DIV*DIV_W-1:0]  DIV_VALS = '0
) (
    input  logic [IDX_W-1:0]  var_idx,
    input  logic [DIDX_W-1:0] div_idx,
    output logic [ADDR_W-1:0] div_ofs,
    output logic [DIV_W-1:0]  div_val
);

    // Offset mux over the divider list
    always_comb begin
        div_ofs = '0;
        for (int d = 0; d < NUM_DIV; d++) begin
            if (div_idx == DIDX_W'(d)) begin
                div_ofs = DIV_OFS[d*ADDR_W +: ADDR_W];
            end
        end
    end

    // Value mux over slot and divider
    always_comb begin
        div_val = '0;
        for (int v = 0; v < NUM_VAR; v++) begin
            for (int d = 0; d < NUM_DIV; d++) begin
                if (var_idx == IDX_W'(v) && div_idx == DIDX_W'(d)) begin
                    div_val = DIV_VALS[(v*NUM_DIV + d)*DIV_W +: DIV_W];
                end
            end
        end
    end

endmodule

// File: rtl/retune_ctrl.sv
`timescale 1ns/1ps
// Sequencer control: accepts a request, picks the write order from the
// new and current PLL rate, steps through the writes one acknowledge at a
// time, and ends every accepted request with a done pulse and a status.
// Assumes: DIV_COUNT live dividers, indexed from 0; wr_resp is valid with wr_ack.
module retune_ctrl #(
    parameter int                RATE_W        = 16,
    parameter int                IDX_W         = 3,
    parameter int                DIDX_W        = 2,
    parameter int                DIV_COUNT     = 4,
    parameter logic [RATE_W-1:0] INIT_PLL_RATE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     hit_idx,
    input  logic [RATE_W-1:0]    hit_pll_rate,
    input  logic                 wr_ack,
    input  logic [1:0]           wr_resp,
    output retune_pkg::phase_e   phase,
    output logic [IDX_W-1:0]     var_idx,
    output logic [DIDX_W-1:0]    div_idx,
    output logic [RATE_W-1:0]    new_rate,
    output logic                 done,
    output logic [1:0]           done_status
);
    import retune_pkg::*;

    localparam int              LAST_DIV   = (DIV_COUNT > 0) ? DIV_COUNT - 1 : 0;
    localparam logic [DIDX_W-1:0] LAST_IDX = DIDX_W'(LAST_DIV);
    localparam bit              HAS_DIVS   = (DIV_COUNT > 0);

    phase_e              phase_q;
    logic [IDX_W-1:0]    var_q;
    logic [DIDX_W-1:0]   div_q;
    logic [RATE_W-1:0]   new_rate_q;
    logic [RATE_W-1:0]   cur_rate_q;
    logic                lower_q;
    logic                done_q;
    logic [1:0]          status_q;
    logic                going_down;

    // Direction of the change for the request being offered
    assign going_down = (hit_pll_rate < cur_rate_q);

    // Phase, indices and end-of-request reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            var_q      <= '0;
            div_q      <= '0;
            new_rate_q <= '0;
            lower_q    <= 1'b0;
            done_q     <= 1'b0;
            status_q   <= ST_OK;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (!hit) begin
                            done_q   <= 1'b1;
                            status_q <= ST_INVALID;
                        end else begin
                            var_q      <= hit_idx;
                            new_rate_q <= hit_pll_rate;
                            lower_q    <= going_down;
                            div_q      <= '0;
                            if (going_down || !HAS_DIVS) begin
                                phase_q <= PH_PLL;
                            end else begin
                                phase_q <= PH_DIV;
                            end
                        end
                    end
                end
                PH_PLL: begin
                    if (wr_ack) begin
                        if (wr_resp == RESP_OK) begin
                            if (lower_q && HAS_DIVS) begin
                                phase_q <= PH_DIV;
                            end else begin
                                phase_q  <= PH_IDLE;
                                done_q   <= 1'b1;
                                status_q <= ST_OK;
                            end
                        end else begin
                            phase_q  <= PH_IDLE;
                            done_q   <= 1'b1;
                            status_q <= (wr_resp == RESP_TIMEOUT) ?
                                        ST_PLL_TIMEOUT : ST_PLL_ERROR;
                        end
                    end
                end
                PH_DIV: begin
                    if (wr_ack) begin
                        if (div_q == LAST_IDX) begin
                            if (lower_q) begin
                                phase_q  <= PH_IDLE;
                                done_q   <= 1'b1;
                                status_q <= ST_OK;
                            end else begin
                                phase_q <= PH_PLL;
                            end
                        end else begin
                            div_q <= div_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Current PLL rate: follows only acknowledged, successful PLL writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_rate_q <= INIT_PLL_RATE;
        end else if (phase_q == PH_PLL && wr_ack && wr_resp == RESP_OK) begin
            cur_rate_q <= new_rate_q;
        end
    end

    assign phase       = phase_q;
    assign var_idx     = var_q;
    assign div_idx     = div_q;
    assign new_rate    = new_rate_q;
    assign done        = done_q;
    assign done_status = status_q;

endmodule

// File: rtl/domain_retune_seq.sv
`timescale 1ns/1ps
// Clock domain retune sequencer top. Looks up the requested rate,
// then programs the PLL and the child dividers over one write port in an
// order that keeps every child clock from overshooting during the change.
// Assumes: RATE_W >= DIV_W; live dividers form a prefix of DIV_OFS ended by
// the first zero offset; PLL_ADDR is nonzero and distinct from divider offsets.
module domain_retune_seq #(
    parameter int NUM_VAR = 6,
    parameter int NUM_DIV = 4,
    parameter int RATE_W  = 16,
    parameter int ADDR_W  = 12,
    parameter int DIV_W   = 8,
    parameter logic [NUM_VAR*RATE_W-1:0] TGT_RATES =
        {16'd150, 16'd125, 16'd100, 16'd75, 16'd50, 16'd25},
    parameter logic [NUM_VAR*RATE_W-1:0] PLL_RATES =
        {16'd600, 16'd750, 16'd600, 16'd600, 16'd600, 16'd600},
    parameter logic [NUM_DIV*ADDR_W-1:0] DIV_OFS =
        {12'h3B0, 12'h3A0, 12'h390, 12'h380},
    parameter logic [NUM_VAR*NUM_DIV*DIV_W-1:0] DIV_VALS =
        {8'd12, 8'd8,  8'd4, 8'd4,
         8'd15, 8'd10, 8'd5, 8'd6,
         8'd12, 8'd8,  8'd4, 8'd6,
         8'd12, 8'd8,  8'd4, 8'd8,
         8'd12, 8'd8,  8'd4, 8'd12,
         8'd12, 8'd8,  8'd4, 8'd24},
    parameter logic [ADDR_W-1:0] PLL_ADDR      = 12'h030,
    parameter logic [RATE_W-1:0] INIT_PLL_RATE = 16'd600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    output logic              busy,
    output logic              wr_valid,
    output logic              wr_to_pll,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [RATE_W-1:0] wr_data,
    input  logic              wr_ack,
    input  logic [1:0]        wr_resp,
    output logic              done,
    output logic [1:0]        done_status
);
    import retune_pkg::*;

    localparam int IDX_W  = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam int DIDX_W = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;

    // Number of dividers before the first zero offset
    function automatic int live_dividers();
        int  n;
        bit  stop;
        n    = 0;
        stop = 1'b0;
        for (int d = 0; d < NUM_DIV; d++) begin
            if (DIV_OFS[d*ADDR_W +: ADDR_W] == '0) stop = 1'b1;
            if (!stop) n++;
        end
        return n;
    endfunction

    localparam int DIV_COUNT = live_dividers();

    logic                hit;
    logic [IDX_W-1:0]    hit_idx;
    logic [RATE_W-1:0]   hit_pll_rate;
    phase_e              phase;
    logic [IDX_W-1:0]    var_idx;
    logic [DIDX_W-1:0]   div_idx;
    logic [RATE_W-1:0]   new_rate;
    logic [ADDR_W-1:0]   div_ofs;
    logic [DIV_W-1:0]    div_val;

    retune_rate_match #(
        .NUM_VAR   (NUM_VAR),
        .RATE_W    (RATE_W),
        .IDX_W     (IDX_W),
        .TGT_RATES (TGT_RATES),
        .PLL_RATES (PLL_RATES)
    ) u_match (
        .req_rate     (req_rate),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .hit_pll_rate (hit_pll_rate)
    );

    retune_ctrl #(
        .RATE_W        (RATE_W),
        .IDX_W         (IDX_W),
        .DIDX_W        (DIDX_W),
        .DIV_COUNT     (DIV_COUNT),
        .INIT_PLL_RATE (INIT_PLL_RATE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .hit          (hit),
        .hit_idx      (hit_idx),
        .hit_pll_rate (hit_pll_rate),
        .wr_ack       (wr_ack),
        .wr_resp      (wr_resp),
        .phase        (phase),
        .var_idx      (var_idx),
        .div_idx      (div_idx),
        .new_rate     (new_rate),
        .done         (done),
        .done_status  (done_status)
    );

    retune_div_table #(
        .NUM_VAR  (NUM_VAR),
        .NUM_DIV  (NUM_DIV),
        .IDX_W    (IDX_W),
        .DIDX_W   (DIDX_W),
        .ADDR_W   (ADDR_W),
        .DIV_W    (DIV_W),
        .DIV_OFS  (DIV_OFS),
        .DIV_VALS (DIV_VALS)
    ) u_table (
        .var_idx (var_idx),
        .div_idx (div_idx),
        .div_ofs (div_ofs),
        .div_val (div_val)
    );

    // Write port: driven from the registered phase and indices
    always_comb begin
        wr_valid  = (phase != PH_IDLE);
        wr_to_pll = (phase == PH_PLL);
        busy      = (phase != PH_IDLE);
        if (phase == PH_PLL) begin
            wr_addr = PLL_ADDR;
            wr_data = new_rate;
        end else begin
            wr_addr = div_ofs;
            wr_data = RATE_W'(div_val);
        end
    end

endmodule

// File: rtl/retune_seq_checker.sv
`timescale 1ns/1ps
// Port-level protocol checker for domain_retune_seq. Keeps its own copy of
// the PLL rate from acknowledged ok PLL writes and checks write ordering.
module retune_seq_checker #(
    parameter int                RATE_W        = 16,
    parameter int                ADDR_W        = 12,
    parameter logic [RATE_W-1:0] INIT_PLL_RATE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              wr_valid,
    input logic              wr_to_pll,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [RATE_W-1:0] wr_data,
    input logic              wr_ack,
    input logic [1:0]        wr_resp,
    input logic              done,
    input logic [1:0]        done_status
);

    logic [RATE_W-1:0] mdl_cur;
    logic [RATE_W-1:0] mdl_prev;
    logic              pll_seen;
    logic              div_seen;

    // Observed PLL rate history and per-request write kinds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdl_cur  <= INIT_PLL_RATE;
            mdl_prev <= INIT_PLL_RATE;
            pll_seen <= 1'b0;
            div_seen <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                pll_seen <= 1'b0;
                div_seen <= 1'b0;
            end
            if (wr_valid && wr_ack) begin
                if (wr_to_pll) begin
                    pll_seen <= 1'b1;
                    if (wr_resp == 2'd0) begin
                        mdl_prev <= mdl_cur;
                        mdl_cur  <= wr_data;
                    end
                end else begin
                    div_seen <= 1'b1;
                end
            end
        end
    end

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ack |=> wr_valid && $stable(wr_to_pll) && $stable(wr_addr) && $stable(wr_data)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_INVALID_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_status == 2'd1 |-> !wr_valid && !$past(wr_valid)); // R2

    AST_LOWER_PLL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_to_pll && pll_seen |-> mdl_cur < mdl_prev); // R3

    AST_RAISE_PLL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_to_pll && div_seen |-> wr_data >= mdl_cur); // R4

    AST_DIV_OFS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_to_pll |-> wr_addr != '0); // R5

    AST_PLL_FAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_to_pll && wr_ack && wr_resp != 2'd0 |=>
        done && !wr_valid && done_status == (($past(wr_resp) == 2'd1) ? 2'd2 : 2'd3)); // R8

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy); // R11

endmodule

bind domain_retune_seq retune_seq_checker #(
    .RATE_W        (RATE_W),
    .ADDR_W        (ADDR_W),
    .INIT_PLL_RATE (INIT_PLL_RATE)
) u_retune_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .wr_valid    (wr_valid),
    .wr_to_pll   (wr_to_pll),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_ack      (wr_ack),
    .wr_resp     (wr_resp),
    .done        (done),
    .done_status (done_status)
);

// File: tb/test_domain_retune_seq.sv
`timescale 1ns/1ps
module test_domain_retune_seq;

    localparam int NV    = 6;
    localparam int ND    = 5;
    localparam int RW    = 16;
    localparam int AW    = 12;
    localparam int DW    = 8;
    localparam int PLL_A = 'h030;
    localparam int INIT  = 600;

    // Bench table: slot 4 is empty, so slot 5 cannot be reached; divider 3 ends the list
    function automatic int tgt_of(input int v);
        case (v)
            0: return 25;  1: return 50;  2: return 75;
            3: return 100; 4: return 0;   default: return 150;
        endcase
    endfunction
    function automatic int pll_of(input int v);
        case (v)
            0: return 600; 1: return 400; 2: return 600;
            3: return 750; 4: return 500; default: return 300;
        endcase
    endfunction
    function automatic int ofs_of(input int d);
        return (d == 3) ? 0 : ('h380 + 16 * d);
    endfunction
    function automatic int val_of(input int v, input int d);
        return 2 * v + d + 1;
    endfunction

    function automatic logic [NV*RW-1:0] pack_tgt();
        logic [NV*RW-1:0] r;
        for (int v = 0; v < NV; v++) r[v*RW +: RW] = RW'(tgt_of(v));
        return r;
    endfunction
    function automatic logic [NV*RW-1:0] pack_pll();
        logic [NV*RW-1:0] r;
        for (int v = 0; v < NV; v++) r[v*RW +: RW] = RW'(pll_of(v));
        return r;
    endfunction
    function automatic logic [ND*AW-1:0] pack_ofs();
        logic [ND*AW-1:0] r;
        for (int d = 0; d < ND; d++) r[d*AW +: AW] = AW'(ofs_of(d));
        return r;
    endfunction
    function automatic logic [NV*ND*DW-1:0] pack_vals();
        logic [NV*ND*DW-1:0] r;
        for (int v = 0; v < NV; v++)
            for (int d = 0; d < ND; d++)
                r[(v*ND + d)*DW +: DW] = DW'(val_of(v, d));
        return r;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [RW-1:0] req_rate = '0;
    logic          busy;
    logic          wr_valid;
    logic          wr_to_pll;
    logic [AW-1:0] wr_addr;
    logic [RW-1:0] wr_data;
    logic          wr_ack = 1'b0;
    logic [1:0]    wr_resp = 2'd0;
    logic          done;
    logic [1:0]    done_status;

    always #2 clk = ~clk;

    domain_retune_seq #(
        .NUM_VAR (NV), .NUM_DIV (ND), .RATE_W (RW), .ADDR_W (AW), .DIV_W (DW),
        .TGT_RATES (pack_tgt()), .PLL_RATES (pack_pll()),
        .DIV_OFS (pack_ofs()), .DIV_VALS (pack_vals()),
        .PLL_ADDR (AW'(PLL_A)), .INIT_PLL_RATE (RW'(INIT))
    ) i_domain_retune_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_rate (req_rate),
        .busy (busy), .wr_valid (wr_valid), .wr_to_pll (wr_to_pll),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_ack (wr_ack),
        .wr_resp (wr_resp), .done (done), .done_status (done_status)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    int  mdl_cur  = INIT;
    bit  finished = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One request: model the expected write list, drive, respond, compare
    task automatic run_req(input int rate, input int pll_resp, input bit poke);
        int e_addr[16]; int e_data[16]; int e_pll[16]; int e_n; int e_st;
        int g_addr[16]; int g_data[16]; int g_pll[16]; int g_n; int g_st;
        int hit; bit lower; bit seen_done; int lat;
        string otag;
        hit = -1;
        for (int v = 0; v < NV; v++) begin
            if (tgt_of(v) == 0) break;
            if (tgt_of(v) == rate) begin hit = v; break; end
        end
        e_n = 0; e_st = 0; lower = 1'b0;
        if (hit < 0) begin
            e_st = 1;
        end else begin
            lower = pll_of(hit) < mdl_cur;
            if (lower) begin
                e_addr[e_n] = PLL_A; e_data[e_n] = pll_of(hit); e_pll[e_n] = 1; e_n++;
            end
            if (!lower || pll_resp == 0) begin
                for (int d = 0; d < ND; d++) begin
                    if (ofs_of(d) == 0) break;
                    e_addr[e_n] = ofs_of(d); e_data[e_n] = val_of(hit, d); e_pll[e_n] = 0; e_n++;
                end
            end
            if (!lower) begin
                e_addr[e_n] = PLL_A; e_data[e_n] = pll_of(hit); e_pll[e_n] = 1; e_n++;
            end
            e_st = (pll_resp == 0) ? 0 : (pll_resp == 1) ? 2 : 3;
            if (pll_resp == 0) mdl_cur = pll_of(hit);
        end
        otag = lower ? "R3" : "R4";

        @(negedge clk);
        req_valid = 1'b1; req_rate = RW'(rate);
        @(negedge clk);
        req_valid = 1'b0;
        g_n = 0; g_st = -1; seen_done = 1'b0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (done) begin
                g_st = int'(done_status); seen_done = 1'b1;
                break;
            end
            if (wr_valid) begin
                if (g_n < 16) begin
                    g_addr[g_n] = int'(wr_addr); g_data[g_n] = int'(wr_data);
                    g_pll[g_n] = int'(wr_to_pll);
                end
                if (g_n == 0) chk("R11", "busy during write", int'(busy), 1);
                lat = (g_n + rate) % 3;
                if (poke && g_n == 0) begin
                    req_valid = 1'b1; req_rate = RW'(tgt_of(0));
                    @(negedge clk);
                    req_valid = 1'b0;
                    chk("R11", "write kept after ignored request", int'(wr_addr), g_addr[0]);
                end
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    chk("R6", "write held while unacknowledged", int'(wr_valid), 1);
                    chk("R6", "address held while unacknowledged", int'(wr_addr), g_addr[g_n]);
                end
                wr_ack = 1'b1;
                wr_resp = wr_to_pll ? 2'(pll_resp) : 2'd0;
                @(negedge clk);
                wr_ack = 1'b0; wr_resp = 2'd0;
                g_n++;
            end else begin
                @(negedge clk);
            end
        end
        chk("R10", "done seen", int'(seen_done), 1);
        chk((e_st == 1) ? "R2" : (e_st >= 2) ? "R8" : "R10", "final status", g_st, e_st);
        chk((hit < 0) ? "R1" : "R5", "write count", g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            if (e_pll[i] == 1) begin
                chk(otag, "position of PLL write", g_pll[i], 1);
                chk("R7", "PLL address", g_addr[i], e_addr[i]);
                chk("R7", "PLL rate", g_data[i], e_data[i]);
            end else begin
                chk(otag, "position of divider write", g_pll[i], 0);
                chk("R5", "divider offset", g_addr[i], e_addr[i]);
                chk("R5", "divider value", g_data[i], e_data[i]);
            end
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R10", "no second done", int'(done), 0);
            chk("R11", "idle after done", int'(wr_valid) + int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "done in reset", int'(done), 0);
        chk("R11", "busy in reset", int'(busy), 0);
        chk("R6", "wr_valid in reset", int'(wr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle after reset", int'(busy) + int'(wr_valid) + int'(done), 0);

        // R9: first request is judged against the initial rate (400 < 600 lowers)
        run_req(tgt_of(1), 0, 1'b0);
        run_req(tgt_of(0), 0, 1'b0);

        // Sweep every ordered pair of live operating points (R3, R4)
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                run_req(tgt_of(a), 0, 1'b0);
                run_req(tgt_of(b), 0, 1'b0);
            end
        end

        // R1 and R2: rates behind the empty slot, zero, and absent rates
        run_req(0, 0, 1'b0);
        run_req(150, 0, 1'b0);
        run_req(33, 0, 1'b0);
        run_req(1000, 0, 1'b0);

        // R8 and R9: failed PLL writes leave the current rate untouched
        run_req(tgt_of(3), 0, 1'b0);
        run_req(tgt_of(1), 1, 1'b0);
        run_req(tgt_of(1), 2, 1'b0);
        run_req(tgt_of(3), 3, 1'b0);
        run_req(tgt_of(1), 0, 1'b0);
        run_req(tgt_of(3), 1, 1'b0);
        run_req(tgt_of(2), 0, 1'b0);

        // R11: a request arriving mid-sequence is ignored
        run_req(tgt_of(3), 0, 1'b1);
        run_req(tgt_of(1), 0, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule